// File: doc/BRIEF.md
# Double-Trap Control Register Slice

This block is the part of a hart's control-register file that holds the supervisor double-trap state for a core with virtualization support. It stores four controls:

- a trap-lock flag (SDT) in the machine status register;
- the matching flag in the virtual-supervisor status register;
- the interrupt-enable bit (SIE) beside each flag;
- a double-trap enable bit (DTE) in each of the machine and hypervisor environment-configuration registers.

It also keeps a few plain pass-through configuration bits, the second trap-value register and the current virtualization mode.

Software reaches the block through a single-cycle CSR port: an address, a write strobe, write data and combinational read data. The read and write accesses can use the 64-bit registers directly. When the 32-bit mode input is high, they can also use the high-half aliases of the environment-configuration registers.

Every write enforces the coupling between the registers:

- Clearing an enable wipes the flags it governs.
- Setting a flag drops the interrupt enable in the same write.
- The hypervisor enable cannot be set while the machine enable is clear.

A mode-toggle pulse exchanges the status bits between the machine and virtual-supervisor copies, as the core does when it changes virtualization mode.

Top module: `dtrap_csr_unit`

## Requirements
- R1: After reset the trap-lock flags, both enable bits, both interrupt enables, the pass-through bits and the mode output are 0.
- R2: The machine status flag (bit 24) changes on a status write only when the enable for the current mode is set: the hypervisor enable when the mode output is 1, the machine enable when it is 0. Otherwise it keeps its value.
- R3: A machine status or supervisor status write that sets bit 24 while the current-mode enable is set leaves SIE (bit 1) at 0 in that same write.
- R4: A write of the machine configuration register (address 0x30A, enable at bit 59) in 64-bit mode clears the machine flag, the hypervisor enable and the virtual flag when its new enable is 0. In 32-bit mode the same holds for the high-half register (address 0x31A, enable at bit 27), and a 0x30A write leaves the enable untouched.
- R5: The hypervisor enable (0x60A bit 59, high half 0x61A bit 27) reads 0 while the machine enable is 0. A write can set it only when the machine enable is already 1.
- R6: Any configuration-register write that leaves the hypervisor enable at 0 clears the virtual flag.
- R7: A virtual status write (address 0x200) with the hypervisor enable set takes bit 24 and forces bit 1 to 0 when bit 24 is 1. With the enable clear, it stores 0 in the virtual flag and takes bit 1 as written.
- R8: The supervisor status view (0x100) shows and writes bit 24 only when the extension parameter is set. Without the extension, both enable bits stay 0.
- R9: The second trap-value register (0x34B) is readable and writable when the extension or the hypervisor parameter is set. Otherwise an access to it raises the fault output, reads 0 and writes nothing.
- R10: Addresses the block does not handle read 0 and leave all state unchanged; the high-half addresses count as unhandled in 64-bit mode. In 32-bit mode, read data bits 63:32 are 0 and a trap-value write keeps only the low 32 bits.
- R11: A toggle pulse inverts the mode output one edge later and swaps SIE between the two status copies. It swaps the flags only when the enable of the mode being left is set. A CSR write in the same cycle is dropped.
- R12: Bits 7:0 of both configuration registers are stored as written and read back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xl32 | input | 1 | 32-bit register-width mode |
| virt_toggle | input | 1 | One-cycle pulse: flip virtualization mode and swap status |
| csr_addr | input | 12 | CSR address |
| csr_we | input | 1 | Write strobe |
| csr_wdata | input | 64 | Write data |
| csr_rdata | output | 64 | Read data for csr_addr |
| csr_fault | output | 1 | Access to the trap-value register when it is absent |
| virt_on | output | 1 | Current virtualization mode |

## Verification
The hardest state to reach is a trap-lock flag that is set while its governing enable is clear. A later write or swap must still treat that flag correctly. The bench gets there by arming the enables, setting the flags, and then clearing or toggling modes in a chosen order. It sweeps every combination of mode, both enables and the two written status bits. Short directed sequences then cover the stale hypervisor enable, the 32-bit high-half aliases and a toggle that lands on the same edge as a write.

// File: rtl/dtrap_pkg.sv
package dtrap_pkg;
   localparam logic [11:0] A_MSTATUS  = 12'h300;
   localparam logic [11:0] A_SSTATUS  = 12'h100;
   localparam logic [11:0] A_VSSTATUS = 12'h200;
   localparam logic [11:0] A_MENVCFG  = 12'h30A;
   localparam logic [11:0] A_MENVCFGH = 12'h31A;
   localparam logic [11:0] A_HENVCFG  = 12'h60A;
   localparam logic [11:0] A_HENVCFGH = 12'h61A;
   localparam logic [11:0] A_MTVAL2   = 12'h34B;

   localparam int SIE_BIT   = 1;
   localparam int SDT_BIT   = 24;
   localparam int DTE64_BIT = 59;
   localparam int DTE32_BIT = 27;

   typedef struct packed {
      logic mstat;
      logic sstat;
      logic vsstat;
      logic menv_lo;
      logic menv_hi;
      logic henv_lo;
      logic henv_hi;
      logic mtv2;
   } dt_sel_t;
endpackage

// File: rtl/dtrap_csr_decode.sv
module dtrap_csr_decode import dtrap_pkg::*; #(
   parameter int ADDR_W = 12,
   parameter bit EXT    = 1'b1,
   parameter bit HYP    = 1'b1
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              xl32,
   output dt_sel_t           sel,
   output logic              mtv2_fault
);
   localparam bit HV     = HYP;
   localparam bit TV2_ON = EXT || HYP;

   always_comb begin
      sel         = '0;
      sel.mstat   = (addr == A_MSTATUS);
      sel.sstat   = (addr == A_SSTATUS);
      sel.vsstat  = HV && (addr == A_VSSTATUS);
      sel.menv_lo = (addr == A_MENVCFG);
      sel.menv_hi = xl32 && (addr == A_MENVCFGH);
      sel.henv_lo = HV && (addr == A_HENVCFG);
      sel.henv_hi = HV && xl32 && (addr == A_HENVCFGH);
      sel.mtv2    = TV2_ON && (addr == A_MTVAL2);
      mtv2_fault  = !TV2_ON && (addr == A_MTVAL2);
   end
endmodule

// File: rtl/dtrap_envcfg.sv
module dtrap_envcfg #(
   parameter bit EXT    = 1'b1,
   parameter int PASS_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              xl32,
   input  logic              we_m_lo,
   input  logic              we_m_hi,
   input  logic              we_h_lo,
   input  logic              we_h_hi,
   input  logic [PASS_W-1:0] wd_pass,
   input  logic              wd_dte64,
   input  logic              wd_dte32,
   output logic              m_dte,
   output logic              h_dte,
   output logic [PASS_W-1:0] m_pass,
   output logic [PASS_W-1:0] h_pass,
   output logic              clr_msdt,
   output logic              clr_vssdt
);
   logic m_dte_wr, h_dte_wr, dte_in;
   logic m_dte_nx, h_dte_nx;

   assign m_dte_wr = (we_m_lo & ~xl32) | we_m_hi;
   assign h_dte_wr = (we_h_lo & ~xl32) | we_h_hi;
   assign dte_in   = xl32 ? wd_dte32 : wd_dte64;

   generate
      if (EXT) begin : g_dte
         // hypervisor enable is kept clean: it can never outlive the machine enable
         assign m_dte_nx = m_dte_wr ? dte_in : m_dte;
         assign h_dte_nx = h_dte_wr ? (dte_in & m_dte) : (h_dte & m_dte_nx);
      end else begin : g_no_dte
         assign m_dte_nx = 1'b0;
         assign h_dte_nx = 1'b0;
      end
   endgenerate

   assign clr_msdt  = m_dte_wr & ~m_dte_nx;
   assign clr_vssdt = (we_m_lo | we_m_hi | we_h_lo | we_h_hi) & ~h_dte_nx;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         m_dte  <= 1'b0;
         h_dte  <= 1'b0;
         m_pass <= '0;
         h_pass <= '0;
      end else begin
         m_dte <= m_dte_nx;
         h_dte <= h_dte_nx;
         if (we_m_lo) m_pass <= wd_pass;
         if (we_h_lo) h_pass <= wd_pass;
      end
   end
endmodule

// File: rtl/dtrap_status.sv
module dtrap_status #(
   parameter bit EXT = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic we_m,
   input  logic we_s,
   input  logic we_vs,
   input  logic w_sie,
   input  logic w_sdt,
   input  logic m_dte,
   input  logic h_dte,
   input  logic clr_msdt,
   input  logic clr_vssdt,
   input  logic swap,
   output logic m_sie,
   output logic m_sdt,
   output logic vs_sie,
   output logic vs_sdt,
   output logic virt
);
   localparam bit S_VIEW_SDT = EXT;

   logic dte_cur, sdt_ok;

   assign dte_cur = virt ? h_dte : m_dte;
   assign sdt_ok  = dte_cur & (we_m | (we_s & S_VIEW_SDT));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         m_sie  <= 1'b0;
         m_sdt  <= 1'b0;
         vs_sie <= 1'b0;
         vs_sdt <= 1'b0;
         virt   <= 1'b0;
      end else if (swap) begin
         virt   <= ~virt;
         m_sie  <= vs_sie;
         vs_sie <= m_sie;
         if (dte_cur) begin
            m_sdt  <= vs_sdt;
            vs_sdt <= m_sdt;
         end
      end else begin
         if (we_m | we_s) begin
            if (sdt_ok) begin
               m_sdt <= w_sdt;
               m_sie <= w_sie & ~w_sdt;
            end else begin
               m_sie <= w_sie;
            end
         end
         if (we_vs) begin
            if (h_dte) begin
               vs_sdt <= w_sdt;
               vs_sie <= w_sie & ~w_sdt;
            end else begin
               vs_sdt <= 1'b0;
               vs_sie <= w_sie;
            end
         end
         if (clr_msdt)  m_sdt  <= 1'b0;
         if (clr_vssdt) vs_sdt <= 1'b0;
      end
   end
endmodule

// File: rtl/dtrap_csr_unit.sv
module dtrap_csr_unit import dtrap_pkg::*; #(
   parameter int XLEN        = 64,
   parameter int ADDR_W      = 12,
   parameter int PASS_W      = 8,
   parameter bit EXT_PRESENT = 1'b1,
   parameter bit HYP_PRESENT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              xl32,
   input  logic              virt_toggle,
   input  logic [ADDR_W-1:0] csr_addr,
   input  logic              csr_we,
   input  logic [XLEN-1:0]   csr_wdata,
   output logic [XLEN-1:0]   csr_rdata,
   output logic              csr_fault,
   output logic              virt_on
);
   localparam int HALF = XLEN / 2;

   generate
      if (XLEN != 64) begin : g_bad_xlen
         $error("dtrap_csr_unit: XLEN must be 64");
      end
      if (ADDR_W != 12) begin : g_bad_aw
         $error("dtrap_csr_unit: ADDR_W must be 12");
      end
      if (PASS_W < 1 || PASS_W > DTE32_BIT) begin : g_bad_pass
         $error("dtrap_csr_unit: PASS_W out of range");
      end
   endgenerate

   dt_sel_t sel;
   logic    wr_ok;
   logic    m_dte, h_dte, clr_msdt, clr_vssdt;
   logic    m_sie, m_sdt, vs_sie, vs_sdt;
   logic [PASS_W-1:0] m_pass, h_pass;
   logic [XLEN-1:0]   mtval2_q, raw;

   dtrap_csr_decode #(.ADDR_W(ADDR_W), .EXT(EXT_PRESENT), .HYP(HYP_PRESENT)) dec_i (
      .addr       (csr_addr),
      .xl32       (xl32),
      .sel        (sel),
      .mtv2_fault (csr_fault)
   );

   // a mode toggle owns the cycle; a coincident write is dropped
   assign wr_ok = csr_we & ~virt_toggle;

   dtrap_envcfg #(.EXT(EXT_PRESENT), .PASS_W(PASS_W)) env_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .xl32      (xl32),
      .we_m_lo   (wr_ok & sel.menv_lo),
      .we_m_hi   (wr_ok & sel.menv_hi),
      .we_h_lo   (wr_ok & sel.henv_lo),
      .we_h_hi   (wr_ok & sel.henv_hi),
      .wd_pass   (csr_wdata[PASS_W-1:0]),
      .wd_dte64  (csr_wdata[DTE64_BIT]),
      .wd_dte32  (csr_wdata[DTE32_BIT]),
      .m_dte     (m_dte),
      .h_dte     (h_dte),
      .m_pass    (m_pass),
      .h_pass    (h_pass),
      .clr_msdt  (clr_msdt),
      .clr_vssdt (clr_vssdt)
   );

   dtrap_status #(.EXT(EXT_PRESENT)) st_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .we_m      (wr_ok & sel.mstat),
      .we_s      (wr_ok & sel.sstat),
      .we_vs     (wr_ok & sel.vsstat),
      .w_sie     (csr_wdata[SIE_BIT]),
      .w_sdt     (csr_wdata[SDT_BIT]),
      .m_dte     (m_dte),
      .h_dte     (h_dte),
      .clr_msdt  (clr_msdt),
      .clr_vssdt (clr_vssdt),
      .swap      (virt_toggle),
      .m_sie     (m_sie),
      .m_sdt     (m_sdt),
      .vs_sie    (vs_sie),
      .vs_sdt    (vs_sdt),
      .virt      (virt_on)
   );

   generate
      if (EXT_PRESENT || HYP_PRESENT) begin : g_mtv2
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               mtval2_q <= '0;
            end else if (wr_ok && sel.mtv2) begin
               mtval2_q <= xl32 ? {{HALF{1'b0}}, csr_wdata[HALF-1:0]} : csr_wdata;
            end
         end
      end else begin : g_no_mtv2
         assign mtval2_q = '0;
      end
   endgenerate

   always_comb begin
      raw = '0;
      if (sel.mstat) begin
         raw[SIE_BIT] = m_sie;
         raw[SDT_BIT] = m_sdt;
      end
      if (sel.sstat) begin
         raw[SIE_BIT] = m_sie;
         raw[SDT_BIT] = m_sdt & EXT_PRESENT;
      end
      if (sel.vsstat) begin
         raw[SIE_BIT] = vs_sie;
         raw[SDT_BIT] = vs_sdt;
      end
      if (sel.menv_lo) begin
         raw[PASS_W-1:0] = m_pass;
         raw[DTE64_BIT]  = m_dte & ~xl32;
      end
      if (sel.menv_hi) raw[DTE32_BIT] = m_dte;
      if (sel.henv_lo) begin
         raw[PASS_W-1:0] = h_pass;
         raw[DTE64_BIT]  = h_dte & m_dte & ~xl32;
      end
      if (sel.henv_hi) raw[DTE32_BIT] = h_dte & m_dte;
      if (sel.mtv2) raw = mtval2_q;
   end

   assign csr_rdata = xl32 ? {{HALF{1'b0}}, raw[HALF-1:0]} : raw;
endmodule

// File: rtl/dtrap_csr_chk.sv
module dtrap_csr_chk import dtrap_pkg::*; (
   input logic        clk,
   input logic        rst_n,
   input logic [11:0] csr_addr,
   input logic        csr_we,
   input logic        w_sdt,
   input logic        w_dte64,
   input logic        xl32,
   input logic        virt_toggle,
   input logic        csr_fault,
   input logic [63:0] csr_rdata,
   input logic        virt_on,
   input logic        m_sdt,
   input logic        m_sie,
   input logic        vs_sdt,
   input logic        m_dte,
   input logic        h_dte
);
   logic wr_now, dte_now;
   assign wr_now  = csr_we && !virt_toggle;
   assign dte_now = virt_on ? h_dte : m_dte;

   // R2
   sdt_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_now && csr_addr == A_MSTATUS && !dte_now) |=> $stable(m_sdt));

   // R3
   sdt_kills_sie_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_now && csr_addr == A_MSTATUS && dte_now && w_sdt) |=> (m_sdt && !m_sie));

   // R4
   menv_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_now && !xl32 && csr_addr == A_MENVCFG && !w_dte64) |=> !m_sdt);

   // R5
   henv_under_menv_chk: assert property (@(posedge clk) disable iff (!rst_n)
      h_dte |-> m_dte);

   // R7
   vs_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_now && csr_addr == A_VSSTATUS && !h_dte) |=> !vs_sdt);

   // R9
   fault_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      csr_fault |-> (csr_rdata == '0));

   // R11
   mode_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      virt_toggle |=> (virt_on != $past(virt_on)));
endmodule

bind dtrap_csr_unit dtrap_csr_chk chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .csr_addr    (csr_addr),
   .csr_we      (csr_we),
   .w_sdt       (csr_wdata[24]),
   .w_dte64     (csr_wdata[59]),
   .xl32        (xl32),
   .virt_toggle (virt_toggle),
   .csr_fault   (csr_fault),
   .csr_rdata   (csr_rdata),
   .virt_on     (virt_on),
   .m_sdt       (m_sdt),
   .m_sie       (m_sie),
   .vs_sdt      (vs_sdt),
   .m_dte       (m_dte),
   .h_dte       (h_dte)
);

// File: tb/dtrap_csr_unit_tb_top.sv
module dtrap_csr_unit_tb_top;
   import dtrap_pkg::*;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        xl32 = 1'b0;
   logic        tgl = 1'b0;
   logic        we = 1'b0;
   logic [11:0] addr = '0;
   logic [63:0] wd = '0;
   logic [63:0] rd, rd2;
   logic        flt, flt2, von, von2;

   always #10 clk = ~clk;

   dtrap_csr_unit dut_i (
      .clk(clk), .rst_n(rst_n), .xl32(xl32), .virt_toggle(tgl),
      .csr_addr(addr), .csr_we(we), .csr_wdata(wd),
      .csr_rdata(rd), .csr_fault(flt), .virt_on(von)
   );

   dtrap_csr_unit #(.EXT_PRESENT(1'b0), .HYP_PRESENT(1'b0)) dut_noext_i (
      .clk(clk), .rst_n(rst_n), .xl32(xl32), .virt_toggle(tgl),
      .csr_addr(addr), .csr_we(we), .csr_wdata(wd),
      .csr_rdata(rd2), .csr_fault(flt2), .virt_on(von2)
   );

   int  n_cmp = 0;
   int  n_bad = 0;
   bit  done  = 1'b0;

   // reference state
   logic md = 0, hd = 0, msdt = 0, msie = 0, vsdt = 0, vsie = 0, virt = 0;
   logic [7:0] mp = 0;

   function automatic logic [63:0] view(input logic sdt, input logic sie);
      logic [63:0] r;
      r = '0;
      r[24] = sdt;
      r[1]  = sie;
      return r;
   endfunction

   function automatic logic [63:0] bit_at(input logic b, input int pos);
      logic [63:0] r;
      r = '0;
      r[pos] = b;
      return r;
   endfunction

   task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string req);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   task automatic rdc(input logic [11:0] a, input logic [63:0] exp, input string req);
      addr = a;
      #2;
      chk(rd, exp, req);
   endtask

   task automatic wr(input logic [11:0] a, input logic [63:0] d);
      @(negedge clk);
      addr = a; wd = d; we = 1'b1;
      @(negedge clk);
      we = 1'b0; wd = '0;
   endtask

   task automatic m_status(input logic [11:0] a, input logic [63:0] d);
      logic dte;
      wr(a, d);
      dte = virt ? hd : md;
      if (dte) begin
         msdt = d[24];
         msie = d[1] & ~d[24];
      end else begin
         msie = d[1];
      end
   endtask

   task automatic vs_status(input logic [63:0] d);
      wr(A_VSSTATUS, d);
      if (hd) begin
         vsdt = d[24];
         vsie = d[1] & ~d[24];
      end else begin
         vsdt = 1'b0;
         vsie = d[1];
      end
   endtask

   task automatic menv(input logic [63:0] d);
      wr(A_MENVCFG, d);
      mp = d[7:0];
      if (!xl32) begin
         md = d[59];
         if (!md) begin msdt = 1'b0; hd = 1'b0; end
      end
      if (!hd) vsdt = 1'b0;
   endtask

   task automatic menvh(input logic [63:0] d);
      wr(A_MENVCFGH, d);
      md = d[27];
      if (!md) begin msdt = 1'b0; hd = 1'b0; end
      if (!hd) vsdt = 1'b0;
   endtask

   task automatic henv(input logic [63:0] d);
      wr(A_HENVCFG, d);
      if (!xl32) hd = d[59] & md;
      if (!hd) vsdt = 1'b0;
   endtask

   task automatic henvh(input logic [63:0] d);
      wr(A_HENVCFGH, d);
      hd = d[27] & md;
      if (!hd) vsdt = 1'b0;
   endtask

   task automatic swap_model();
      logic t;
      t = msie; msie = vsie; vsie = t;
      if (virt ? hd : md) begin
         t = msdt; msdt = vsdt; vsdt = t;
      end
      virt = ~virt;
   endtask

   task automatic tog();
      @(negedge clk);
      tgl = 1'b1;
      @(negedge clk);
      tgl = 1'b0;
      swap_model();
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rdc(A_MSTATUS, 64'h0, "R1");
      rdc(A_VSSTATUS, 64'h0, "R1");
      rdc(A_MENVCFG, 64'h0, "R1");
      rdc(A_HENVCFG, 64'h0, "R1");
      chk({63'b0, von}, 64'h0, "R1");

      // R12 pass-through bits
      menv(64'hA5);
      rdc(A_MENVCFG, 64'hA5, "R12");
      henv(64'h3C);
      rdc(A_HENVCFG, 64'h3C, "R12");
      menv(64'h0);
      henv(64'h0);

      // R2 R3 R5 R7 R8 sweep over mode, both enables and written bits
      for (int v = 0; v < 2; v++) begin
         for (int mdi = 0; mdi < 2; mdi++) begin
            for (int hdi = 0; hdi < 2; hdi++) begin
               for (int s = 0; s < 2; s++) begin
                  for (int i = 0; i < 2; i++) begin
                     if (virt != v[0]) tog();
                     menv(bit_at(mdi[0], 59));
                     henv(bit_at(hdi[0], 59));
                     rdc(A_HENVCFG, bit_at(hd & md, 59), "R5");
                     m_status(A_MSTATUS, view(s[0], i[0]));
                     rdc(A_MSTATUS, view(msdt, msie), "R2 R3");
                     rdc(A_SSTATUS, view(msdt, msie), "R8");
                     vs_status(view(s[0], i[0]));
                     rdc(A_VSSTATUS, view(vsdt, vsie), "R7");
                  end
               end
            end
         end
      end
      if (virt) tog();

      // R8 sstatus write path
      menv(bit_at(1'b1, 59));
      m_status(A_SSTATUS, view(1'b1, 1'b1));
      rdc(A_SSTATUS, view(1'b1, 1'b0), "R8");

      // R4 machine enable clear wipes flag
      m_status(A_MSTATUS, view(1'b1, 1'b0));
      rdc(A_MSTATUS, view(1'b1, 1'b0), "R4");
      menv(64'h0);
      rdc(A_MSTATUS, view(msdt, msie), "R4");

      // R6 hypervisor enable clear wipes virtual flag
      menv(bit_at(1'b1, 59));
      henv(bit_at(1'b1, 59));
      vs_status(view(1'b1, 1'b0));
      rdc(A_VSSTATUS, view(1'b1, 1'b0), "R6");
      henv(64'h0);
      rdc(A_VSSTATUS, view(vsdt, vsie), "R6");

      // R5 stale hypervisor enable after machine enable drop
      henv(bit_at(1'b1, 59));
      menv(64'h0);
      rdc(A_HENVCFG, 64'h0, "R5");
      menv(bit_at(1'b1, 59));
      rdc(A_HENVCFG, 64'h0, "R5");

      // R10 unhandled addresses
      m_status(A_MSTATUS, view(1'b1, 1'b0));
      wr(12'h123, '1);
      rdc(12'h123, 64'h0, "R10");
      rdc(A_MSTATUS, view(msdt, msie), "R10");
      wr(A_MENVCFGH, 64'h0);
      rdc(A_MENVCFGH, 64'h0, "R10");
      rdc(A_MSTATUS, view(msdt, msie), "R10");
      rdc(A_MENVCFG, bit_at(md, 59) | {56'b0, mp}, "R10");

      // R11 swap sweep
      for (int mdi = 0; mdi < 2; mdi++) begin
         for (int hdi = 0; hdi < 2; hdi++) begin
            menv(bit_at(mdi[0], 59));
            henv(bit_at(hdi[0], 59));
            m_status(A_MSTATUS, view(1'b1, 1'b1));
            vs_status(view(1'b0, 1'b1));
            if (hd) vs_status(view(1'b1, 1'b0));
            tog();
            chk({63'b0, von}, 64'h1, "R11");
            rdc(A_MSTATUS, view(msdt, msie), "R11");
            rdc(A_VSSTATUS, view(vsdt, vsie), "R11");
            tog();
            chk({63'b0, von}, 64'h0, "R11");
            rdc(A_MSTATUS, view(msdt, msie), "R11");
            rdc(A_VSSTATUS, view(vsdt, vsie), "R11");
         end
      end

      // R11 toggle wins over a coincident write
      @(negedge clk);
      addr = A_MSTATUS; wd = view(1'b0, ~msie); we = 1'b1; tgl = 1'b1;
      @(negedge clk);
      we = 1'b0; tgl = 1'b0; wd = '0;
      swap_model();
      rdc(A_MSTATUS, view(msdt, msie), "R11");
      tog();

      // R4 R5 R10 in 32-bit mode
      xl32 = 1'b1;
      menvh(bit_at(1'b1, 27));
      rdc(A_MENVCFGH, bit_at(1'b1, 27), "R4");
      m_status(A_MSTATUS, view(1'b1, 1'b0));
      menv(64'h0000_0000_0000_0011);
      rdc(A_MENVCFG, 64'h11, "R4");
      rdc(A_MSTATUS, view(1'b1, 1'b0), "R4");
      menvh(64'h0);
      rdc(A_MSTATUS, view(msdt, msie), "R4");
      menvh(bit_at(1'b1, 27));
      henvh(bit_at(1'b1, 27));
      rdc(A_HENVCFGH, bit_at(1'b1, 27), "R5");
      wr(A_MTVAL2, 64'hDEAD_BEEF_1234_5678);
      rdc(A_MTVAL2, 64'h0000_0000_1234_5678, "R10");
      xl32 = 1'b0;

      // R9 trap-value register access
      wr(A_MTVAL2, 64'hCAFE_F00D_8765_4321);
      rdc(A_MTVAL2, 64'hCAFE_F00D_8765_4321, "R9");
      chk({63'b0, flt}, 64'h0, "R9");
      addr = A_MTVAL2;
      #2;
      chk({63'b0, flt2}, 64'h1, "R9");
      chk(rd2, 64'h0, "R9");

      // R8 no extension: enables and flag stay 0
      menv(bit_at(1'b1, 59));
      addr = A_MENVCFG;
      #2;
      chk(rd2, 64'h0, "R8");
      m_status(A_MSTATUS, view(1'b1, 1'b1));
      addr = A_MSTATUS;
      #2;
      chk({63'b0, rd2[24]}, 64'h0, "R8");
      addr = A_SSTATUS;
      #2;
      chk({63'b0, rd2[24]}, 64'h0, "R8");

      finish_run();
   end
endmodule